// File: doc/BRIEF.md
# Multiplexed-Strobe Dynamic Memory Emulator

This block is a cycle-level, synthesizable stand-in for a 16K x 1 dynamic memory. It is meant to sit behind a memory controller under test. It stores data in an internal array, and it reports when the controller breaks the strobe protocol or lets a row go unrefreshed for too long. A 7-bit address bus carries the row address and then the column address. Three active-low strobes (row, column, write) and a one-bit data input drive the model. A one-bit data output is qualified by an output-enable that stands in for a three-state buffer.

All strobes are plain control pins sampled on the rising edge of `clk`, so the controller must drive them synchronously. The pins are not a stream: there is no valid/ready pair and no back-pressure. An edge of a strobe is the first sample at which it reads low after having read high.

- A row strobe edge opens a row and also counts as a refresh of that row.
- Each column strobe edge within an open row is one access.
  - If the write strobe is already low at that sample, the access is an early write.
  - Otherwise it is a read, whose data appears after a fixed latency.
- Two sticky flags report protocol breaches:
  - a column strobe with no open row;
  - a row left unactivated longer than a parameterised limit.

Top module: `dram_emu`

## Requirements
- R1: After reset `dout_en`, `dout`, `proto_err` and `ret_err` are all 0.
- R2: The row address is taken from `addr` at the first sample with `ras_n` low. The column address is taken at the first sample with `cas_n` low, and only if `ras_n` was low at that sample and at the one before it. Changes on `addr` or `din` after these samples do not alter the access.
- R3: If `we_n` is 0 at the column sample, `din` is stored at (row, column), and `dout_en` stays 0 for the rest of that column cycle.
- R4: For a read, `dout_en` becomes 1 after the RD_LAT-th rising edge that follows the column sample. While `dout_en` is 1, `dout` equals the stored bit.
- R5: `dout_en` is 0 whenever `cas_n` is 1, with no clock delay, so nothing is held after the cycle ends. `dout` is 0 whenever `dout_en` is 0.
- R6: While `ras_n` stays low, every fresh fall of `cas_n` makes a new access to a new column of the same latched row (page mode).
- R7: A row-strobe-only cycle moves no data and never enables the output. It restarts the age of the selected row.
- R8: A column strobe fall sampled when `ras_n` was 1 at the previous sample stores nothing and drives no output. It sets `proto_err`, visible after that edge, and `proto_err` stays 1 until reset.
- R9: Each row counts rising edges since its last row strobe edge, or since reset. `ret_err` rises at the edge after any row's count exceeds RETAIN, that is RETAIN+2 edges after its last activation, and it stays 1 until reset.
- R10: Pulling `we_n` low only after the column sample of a read stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | AW | Multiplexed row / column address |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| din | input | 1 | Write data |
| dout | output | 1 | Read data, 0 when not enabled |
| dout_en | output | 1 | Output buffer enable |
| proto_err | output | 1 | Sticky column-without-row flag |
| ret_err | output | 1 | Sticky retention-overrun flag |

## Verification
Call the edge that samples the column strobe fall E0.

- **Write data** is in the array at E0 itself.
- **Read enable** rises only after edge E0+RD_LAT. The bench checks that it is still low one edge earlier and high on that edge.
- **Enable drop** follows a rising `cas_n` within the same cycle. The bench raises the strobe between edges and samples one nanosecond later.
- **Protocol flag** is due after E0.
- **Retention flag** is due RETAIN+2 edges after a row's last activation.

A behavioural model in the bench counts edges since reset and predicts every output for the current cycle. It is compared on each falling clock edge, so every output is checked away from the edge that moves it.

// File: rtl/dram_emu_pkg.sv
package dram_emu_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;
endpackage

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl
  import dram_emu_pkg::*;
#(
  parameter int AW     = 7,
  parameter int RD_LAT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  output logic          act_stb,
  output logic [AW-1:0] act_row,
  output logic          wr_en,
  output logic [AW-1:0] cur_row,
  output logic [AW-1:0] cur_col,
  output logic [AW-1:0] wr_col,
  output logic          rd_ready,
  output logic          proto_err
);
  localparam int CNT_W = $clog2(RD_LAT + 1);

  logic            ras_q, cas_q;
  logic [AW-1:0]   row_q, col_q;
  cyc_e            cyc_q;
  logic [CNT_W-1:0] cnt_q;
  logic            perr_q;
  logic            ras_fall, cas_fall, row_open;

  assign ras_fall = ras_q & ~ras_n;
  assign cas_fall = cas_q & ~cas_n;
  assign row_open = ~ras_q & ~ras_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
      row_q  <= '0;
      col_q  <= '0;
      cyc_q  <= CYC_IDLE;
      cnt_q  <= '0;
      perr_q <= 1'b0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      if (ras_fall) row_q <= addr;
      if (cas_n || ras_n) cyc_q <= CYC_IDLE;
      if (cas_fall) begin
        if (row_open) begin
          col_q <= addr;
          if (!we_n) begin
            cyc_q <= CYC_WRITE;
          end else begin
            cyc_q <= CYC_READ;
            cnt_q <= CNT_W'(RD_LAT);
          end
        end else begin
          perr_q <= 1'b1;
        end
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign act_stb   = ras_fall;
  assign act_row   = addr;
  assign wr_en     = cas_fall & row_open & ~we_n;
  assign wr_col    = addr;
  assign cur_row   = row_q;
  assign cur_col   = col_q;
  assign rd_ready  = (cyc_q == CYC_READ) && (cnt_q == '0);
  assign proto_err = perr_q;
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_row,
  input  logic [AW-1:0] wr_col,
  input  logic          wr_bit,
  input  logic [AW-1:0] rd_row,
  input  logic [AW-1:0] rd_col,
  output logic          rd_bit
);
  localparam int NROW = 1 << AW;
  localparam int NCOL = 1 << AW;

  logic [NCOL-1:0] cells [NROW];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_row][wr_col] <= wr_bit;
  end

  assign rd_bit = cells[rd_row][rd_col];
endmodule

// File: rtl/dram_retention_mon.sv
module dram_retention_mon #(
  parameter int AW     = 7,
  parameter int RETAIN = 250000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act_stb,
  input  logic [AW-1:0] act_row,
  output logic          ret_err
);
  localparam int NROW  = 1 << AW;
  localparam int AGE_W = $clog2(RETAIN + 2);
  localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(RETAIN + 1);

  logic [NROW-1:0] over;
  logic            err_q;

  for (genvar r = 0; r < NROW; r++) begin : g_row
    logic [AGE_W-1:0] age_q;
    always_ff @(posedge clk) begin
      if (rst)                                 age_q <= '0;
      else if (act_stb && act_row == AW'(r))   age_q <= '0;
      else if (age_q != AGE_SAT)               age_q <= age_q + 1'b1;
    end
    assign over[r] = (age_q == AGE_SAT);
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= err_q | (|over);
  end

  assign ret_err = err_q;
endmodule

// File: rtl/dram_emu.sv
module dram_emu #(
  parameter int AW     = 7,
  parameter int RD_LAT = 2,
  parameter int RETAIN = 250000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic          din,
  output logic          dout,
  output logic          dout_en,
  output logic          proto_err,
  output logic          ret_err
);
  logic          act_stb, wr_en, rd_ready, rd_bit;
  logic [AW-1:0] act_row, cur_row, cur_col, wr_col;

  dram_strobe_ctrl #(.AW(AW), .RD_LAT(RD_LAT)) u_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .act_stb(act_stb), .act_row(act_row), .wr_en(wr_en),
    .cur_row(cur_row), .cur_col(cur_col), .wr_col(wr_col),
    .rd_ready(rd_ready), .proto_err(proto_err)
  );

  dram_cell_array #(.AW(AW)) u_cells (
    .clk(clk), .wr_en(wr_en), .wr_row(cur_row), .wr_col(wr_col),
    .wr_bit(din), .rd_row(cur_row), .rd_col(cur_col), .rd_bit(rd_bit)
  );

  dram_retention_mon #(.AW(AW), .RETAIN(RETAIN)) u_ret (
    .clk(clk), .rst(rst), .act_stb(act_stb), .act_row(act_row),
    .ret_err(ret_err)
  );

  assign dout_en = rd_ready & ~cas_n;
  assign dout    = dout_en & rd_bit;
endmodule

// File: rtl/dram_emu_chk.sv
module dram_emu_chk (
  input logic clk,
  input logic rst,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic dout,
  input logic dout_en,
  input logic proto_err,
  input logic ret_err
);
  p_oe_needs_cas_r5: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> !cas_n);

  p_dout_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !dout_en |-> !dout);

  p_no_oe_at_sample_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |-> !dout_en);

  p_early_write_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(cas_n) && !$past(ras_n) && !ras_n && !we_n) |=> !dout_en);

  p_proto_set_r8: assert property (@(posedge clk) disable iff (rst)
    ($fell(cas_n) && $past(ras_n)) |=> proto_err);

  p_proto_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);

  p_ret_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    ret_err |=> ret_err);
endmodule

bind dram_emu dram_emu_chk u_chk (
  .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .dout(dout), .dout_en(dout_en), .proto_err(proto_err), .ret_err(ret_err)
);

// File: tb/sim_dram_emu.sv
module sim_dram_emu;
  localparam int AW     = 7;
  localparam int RD_LAT = 3;
  localparam int RETAIN = 3000;
  localparam int NR     = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
  logic dout, dout_en, proto_err, ret_err;

  always #4 clk = ~clk;

  dram_emu #(.AW(AW), .RD_LAT(RD_LAT), .RETAIN(RETAIN)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .din(din), .dout(dout), .dout_en(dout_en),
    .proto_err(proto_err), .ret_err(ret_err)
  );

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: edge count since reset, last activation per row
  int n = 0;
  bit m_rasp = 1, m_casp = 1, m_rd = 0, m_perr = 0, m_ret = 0;
  int m_row = 0, m_col = 0, m_tr = 0;
  int last [NR];
  bit mem_m [int];

  always @(posedge clk) begin
    if (rst) begin
      n = 0; m_rasp = 1; m_casp = 1; m_rd = 0; m_perr = 0; m_ret = 0;
      m_row = 0; m_col = 0;
      for (int r = 0; r < NR; r++) last[r] = 0;
    end else begin
      n++;
      for (int r = 0; r < NR; r++) if ((n - 1 - last[r]) > RETAIN) m_ret = 1;
      if (!ras_n && m_rasp) begin
        m_row = int'(addr);
        last[int'(addr)] = n;
      end
      if (cas_n || ras_n) m_rd = 0;
      if (!cas_n && m_casp) begin
        if (!m_rasp && !ras_n) begin
          m_col = int'(addr);
          if (!we_n) begin
            mem_m[m_row * NR + m_col] = din;
            m_rd = 0;
          end else begin
            m_rd = 1;
            m_tr = n;
          end
        end else begin
          m_perr = 1;
        end
      end
      m_rasp = ras_n;
      m_casp = cas_n;
    end
  end

  always @(negedge clk) begin
    if (!rst && n > 0 && !done) begin
      bit en_x, d_x;
      int k;
      k    = m_row * NR + m_col;
      en_x = m_rd && ((n - m_tr) >= RD_LAT) && !cas_n;
      d_x  = en_x && mem_m.exists(k) ? mem_m[k] : 1'b0;
      chk("R4/R5 model enable", dout_en, en_x);
      chk("R4/R5 model data", dout, d_x);
      chk("R8 model proto_err", proto_err, m_perr);
      chk("R9 model ret_err", ret_err, m_ret);
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic do_write(int r, int c, logic d);
    addr = AW'(r); ras_n = 0; tick();
    addr = AW'(c); we_n = 0; din = d; cas_n = 0; tick();
    addr = ~AW'(c); din = ~d; tick();
    #1 chk("R3 no enable in write", dout_en, 0);
    cas_n = 1; we_n = 1; tick();
    ras_n = 1; tick(); tick();
  endtask

  task automatic do_read(int r, int c, logic exp, string tag);
    addr = AW'(r); ras_n = 0; tick();
    addr = AW'(c); cas_n = 0; tick();
    addr = ~AW'(c);
    repeat (RD_LAT - 1) tick();
    #1 chk({tag, " R4 enable early"}, dout_en, 0);
    tick();
    #1 chk({tag, " R4 enable due"}, dout_en, 1);
    chk({tag, " R2 data"}, dout, exp);
    cas_n = 1;
    #1 chk("R5 enable drop", dout_en, 0);
    chk("R5 data idle", dout, 0);
    tick();
    ras_n = 1; tick(); tick();
  endtask

  function automatic int row_of(int i); return (i * 37 + 3) % NR; endfunction
  function automatic int col_of(int i); return (i * 53 + 11) % NR; endfunction
  function automatic logic bit_of(int i); return logic'((i ^ (i >> 1)) & 1); endfunction

  initial begin
    repeat (3) tick();
    rst = 0; tick();
    #1 chk("R1 dout_en", dout_en, 0);
    chk("R1 dout", dout, 0);
    chk("R1 proto_err", proto_err, 0);
    chk("R1 ret_err", ret_err, 0);
    tick();

    for (int i = 0; i < 12; i++) do_write(row_of(i), col_of(i), bit_of(i));
    for (int i = 11; i >= 0; i--) do_read(row_of(i), col_of(i), bit_of(i), "R3 readback");

    // page mode on row 20
    do_write(20, 4, 1); do_write(20, 5, 0); do_write(20, 6, 1); do_write(20, 7, 1);
    addr = 20; ras_n = 0; tick();
    for (int k = 4; k < 8; k++) begin
      addr = AW'(k); cas_n = 0; tick();
      addr = '0;
      repeat (RD_LAT) tick();
      #1 chk("R6 page enable", dout_en, 1);
      chk("R6 page data", dout, (k == 5) ? 0 : 1);
      cas_n = 1; tick();
    end
    ras_n = 1; tick(); tick();

    // late write must not store
    addr = 20; ras_n = 0; tick();
    addr = 5; cas_n = 0; tick();
    we_n = 0; din = 1; tick(); tick();
    cas_n = 1; we_n = 1; tick();
    ras_n = 1; tick(); tick();
    do_read(20, 5, 0, "R10 late write ignored");

    // column strobe without row
    #1 chk("R8 proto clear before", proto_err, 0);
    tick();
    addr = 5; we_n = 0; din = 1; cas_n = 0; tick();
    #1 chk("R8 proto set", proto_err, 1);
    chk("R8 no enable", dout_en, 0);
    cas_n = 1; we_n = 1; tick(); tick();
    do_read(20, 5, 0, "R8 no store");

    // refresh sweep
    for (int r = 0; r < NR; r++) begin
      addr = AW'(r); ras_n = 0; tick(); tick();
      #1 chk("R7 refresh no enable", dout_en, 0);
      ras_n = 1; tick(); tick();
    end
    while (n < 3100) tick();
    #1 chk("R7 refresh restarts age", ret_err, 0);
    while (n < 5200) tick();
    #1 chk("R9 retention overrun", ret_err, 1);
    tick();
    #1 chk("R9 retention sticky", ret_err, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errs++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule